// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the eight-bit condition and mode register of a small accumulator-style CPU and decides, for each executed operation, which flags change and to what. The execution stage presents one operation per cycle: its class, the eight-bit result, the ninth (carry/borrow) bit, the two operand values, a flag selector for set/clear operations and the break indication for a status push. The unit registers the new flags at the next clock edge. It also gives them out individually so that branch logic and the interrupt front end can use them.

The operation interface is a valid/ready stream. `op_ready` is always high because the register accepts a new update every cycle, so the sender never sees back-pressure. An operation counts only in a cycle where `op_valid` is high. The packed byte `psr_o` is the value a status push would write to memory. The break bit in that byte comes straight from `brk_in`, because the stored register has no storage for it. A maskable request on `irq_req` passes to `irq_take` only while the interrupt-disable flag is clear.

Top module: `status_flag_unit`

## Requirements
- R1: `psr_o` bit layout, most significant first, is N(7), V(6), constant 1(5), B(4), D(3), I(2), Z(1), C(0). Bit 5 always reads 1, and bit 4 equals `brk_in` in the same cycle.
- R2: After reset, I is 1 and N, V, D, Z and C are 0, so `psr_o` is 8'h24 when `brk_in` is 0.
- R3: Class codes on `op_class` are: load/transfer 0, logical 1, add 2, subtract 3, compare 4, shift/rotate 5, bit-test 6, pull-status 7, set/clear 8. For classes 0 to 5, the next N is `op_result[7]` and the next Z is 1 exactly when `op_result` is zero.
- R4: For classes add, subtract, compare and shift/rotate, the next C equals `op_carry`. For subtract and compare, `op_carry` is 1 when no borrow occurred.
- R5: Add sets V to (a7 == b7) && (r7 != a7). Subtract sets V to (a7 != b7) && (r7 != a7). Here a is `op_a`, b is `op_b` and r is `op_result`; for example, 8'h55 + 8'h2D = 8'h82 gives V = 1.
- R6: Load/transfer and logical classes leave V, C, D and I unchanged. Compare and shift/rotate leave V, D and I unchanged.
- R7: Bit-test sets N to `op_b[7]` and V to `op_b[6]`, and sets Z to 1 when (`op_a` & `op_b`) is zero. C, D and I are unchanged, and `op_result` is ignored.
- R8: Pull-status loads N, V, D, I, Z and C from the corresponding bit positions of `op_result`. Bits 5 and 4 of `op_result` are ignored.
- R9: Set/clear writes `flag_val` into the flag at bit position `flag_sel` when `flag_sel` is 0 (C), 1 (Z), 2 (I), 3 (D) or 6 (V). Selector values 4, 5 and 7 change nothing.
- R10: `irq_take` is `irq_req` while I is 0, and 0 while I is 1.
- R11: A cycle with `op_valid` low, or with a class code from 9 to 15, changes no flag. `op_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation's flag update is presented this cycle |
| op_ready | output | 1 | Always 1; an update is accepted every cycle |
| op_class | input | 4 | Operation class code (see R3) |
| op_result | input | 8 | Eight-bit result, or the status byte being pulled |
| op_carry | input | 1 | Ninth result bit (carry out, or not-borrow) |
| op_a | input | 8 | First operand (accumulator side) |
| op_b | input | 8 | Second operand (memory side) |
| flag_sel | input | 3 | Bit position targeted by set/clear |
| flag_val | input | 1 | Value written by set/clear |
| brk_in | input | 1 | Break indication placed in bit 4 of the pushed byte |
| irq_req | input | 1 | Maskable interrupt request |
| psr_o | output | 8 | Packed status byte as it would be pushed |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_d | output | 1 | Decimal-mode flag |
| flag_i | output | 1 | Interrupt-disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| irq_take | output | 1 | Request passed on when unmasked |

## Verification
On every cycle, the assertions check these rules:
- every flag without a write enable holds its value;
- N, Z and C follow the presented result and carry one cycle later for the classes that write them;
- bit-test copies the operand bits into N and V;
- pull-status lands in the stored flags;
- loads and logical operations leave V and C unchanged.

The bench scenarios cover the rest:
- the exact overflow values for signed add and subtract corner cases;
- the reset value;
- the set/clear selector codes that must be ignored;
- unused class codes;
- the masking of interrupt requests around set and clear of I;
- a zero-result carry case.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;

  typedef enum logic [3:0] {
    CLS_LOAD   = 4'd0,
    CLS_LOGIC  = 4'd1,
    CLS_ADD    = 4'd2,
    CLS_SUB    = 4'd3,
    CLS_CMP    = 4'd4,
    CLS_SHIFT  = 4'd5,
    CLS_BITT   = 4'd6,
    CLS_PULL   = 4'd7,
    CLS_SETCLR = 4'd8
  } op_class_e;

  // Flag positions inside the status byte.
  localparam int unsigned PB_C   = 0;
  localparam int unsigned PB_Z   = 1;
  localparam int unsigned PB_I   = 2;
  localparam int unsigned PB_D   = 3;
  localparam int unsigned PB_B   = 4;
  localparam int unsigned PB_ONE = 5;
  localparam int unsigned PB_V   = 6;
  localparam int unsigned PB_N   = 7;

  localparam int unsigned PSR_W  = 8;

endpackage

// File: rtl/flag_next.sv
`timescale 1ns/1ps
module flag_next
  import psr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             op_valid,
  input  logic [3:0]       op_class,
  input  logic [DW-1:0]    op_result,
  input  logic             op_carry,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  input  logic [2:0]       flag_sel,
  input  logic             flag_val,
  input  logic [PSR_W-1:0] cur_i,
  output logic [PSR_W-1:0] nxt_o,
  output logic [PSR_W-1:0] wmask_o
);
  localparam int unsigned MSB = DW - 1;

  logic res_zero, res_neg, v_add, v_sub, sel_ok;

  always_comb begin
    res_zero = (op_result == '0);
    res_neg  = op_result[MSB];
    v_add    = ~(op_a[MSB] ^ op_b[MSB]) & (op_a[MSB] ^ op_result[MSB]);
    v_sub    =  (op_a[MSB] ^ op_b[MSB]) & (op_a[MSB] ^ op_result[MSB]);
    sel_ok   = (flag_sel == 3'(PB_C)) || (flag_sel == 3'(PB_Z)) ||
               (flag_sel == 3'(PB_I)) || (flag_sel == 3'(PB_D)) ||
               (flag_sel == 3'(PB_V));
  end

  always_comb begin
    nxt_o   = cur_i;
    wmask_o = '0;
    if (op_valid) begin
      case (op_class)
        CLS_LOAD, CLS_LOGIC: begin
          nxt_o[PB_N] = res_neg;  wmask_o[PB_N] = 1'b1;
          nxt_o[PB_Z] = res_zero; wmask_o[PB_Z] = 1'b1;
        end
        CLS_ADD, CLS_SUB: begin
          nxt_o[PB_N] = res_neg;  wmask_o[PB_N] = 1'b1;
          nxt_o[PB_Z] = res_zero; wmask_o[PB_Z] = 1'b1;
          nxt_o[PB_C] = op_carry; wmask_o[PB_C] = 1'b1;
          nxt_o[PB_V] = (op_class == CLS_ADD) ? v_add : v_sub;
          wmask_o[PB_V] = 1'b1;
        end
        CLS_CMP, CLS_SHIFT: begin
          nxt_o[PB_N] = res_neg;  wmask_o[PB_N] = 1'b1;
          nxt_o[PB_Z] = res_zero; wmask_o[PB_Z] = 1'b1;
          nxt_o[PB_C] = op_carry; wmask_o[PB_C] = 1'b1;
        end
        CLS_BITT: begin
          nxt_o[PB_N] = op_b[MSB];               wmask_o[PB_N] = 1'b1;
          nxt_o[PB_V] = op_b[MSB-1];             wmask_o[PB_V] = 1'b1;
          nxt_o[PB_Z] = ((op_a & op_b) == '0);   wmask_o[PB_Z] = 1'b1;
        end
        CLS_PULL: begin
          nxt_o   = op_result[PSR_W-1:0];
          wmask_o = ~((PSR_W)'(1) << PB_B | (PSR_W)'(1) << PB_ONE);
        end
        CLS_SETCLR: begin
          if (sel_ok) begin
            nxt_o[flag_sel]   = flag_val;
            wmask_o[flag_sel] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flag_store.sv
`timescale 1ns/1ps
module flag_store
  import psr_pkg::*;
#(
  parameter logic [PSR_W-1:0] RST_VAL = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSR_W-1:0] nxt_i,
  input  logic [PSR_W-1:0] wmask_i,
  output logic [PSR_W-1:0] q_o
);
  for (genvar b = 0; b < PSR_W; b++) begin : g_bit
    if (b == PB_ONE) begin : g_one
      assign q_o[b] = 1'b1;
    end else if (b == PB_B) begin : g_brk
      assign q_o[b] = 1'b0;
    end else begin : g_ff
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)          q <= RST_VAL[b];
        else if (wmask_i[b]) q <= nxt_i[b];
      end
      assign q_o[b] = q;

      // R11: a flag without a write enable keeps its value
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wmask_i[b] |=> (q_o[b] == $past(q_o[b])));
    end
  end
endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
  import psr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [3:0]    op_class,
  input  logic [DW-1:0] op_result,
  input  logic          op_carry,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [2:0]    flag_sel,
  input  logic          flag_val,
  input  logic          brk_in,
  input  logic          irq_req,
  output logic [7:0]    psr_o,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_d,
  output logic          flag_i,
  output logic          flag_z,
  output logic          flag_c,
  output logic          irq_take
);
  logic [PSR_W-1:0] cur, nxt, wmask;

  flag_next #(.DW(DW)) u_next (
    .op_valid (op_valid),
    .op_class (op_class),
    .op_result(op_result),
    .op_carry (op_carry),
    .op_a     (op_a),
    .op_b     (op_b),
    .flag_sel (flag_sel),
    .flag_val (flag_val),
    .cur_i    (cur),
    .nxt_o    (nxt),
    .wmask_o  (wmask)
  );

  flag_store #(.RST_VAL(8'h04)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .nxt_i  (nxt),
    .wmask_i(wmask),
    .q_o    (cur)
  );

  assign op_ready = 1'b1;
  assign psr_o    = {cur[PB_N], cur[PB_V], cur[PB_ONE], brk_in, cur[PB_D:PB_C]};
  assign flag_n   = cur[PB_N];
  assign flag_v   = cur[PB_V];
  assign flag_d   = cur[PB_D];
  assign flag_i   = cur[PB_I];
  assign flag_z   = cur[PB_Z];
  assign flag_c   = cur[PB_C];
  assign irq_take = irq_req & ~cur[PB_I];

  logic nz_cls, c_cls, keep_vc_cls;
  assign nz_cls      = op_valid && (op_class <= 4'(CLS_SHIFT));
  assign c_cls       = op_valid && (op_class >= 4'(CLS_ADD)) && (op_class <= 4'(CLS_SHIFT));
  assign keep_vc_cls = op_valid && (op_class <= 4'(CLS_LOGIC));

  // R3: N and Z follow the presented result one cycle later
  a_r3_nz_follow: assert property (@(posedge clk) disable iff (!rst_n)
    nz_cls |=> (flag_n == $past(op_result[DW-1])) && (flag_z == ($past(op_result) == '0)));

  // R4: C follows the ninth bit
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    c_cls |=> (flag_c == $past(op_carry)));

  // R6: loads and logical operations keep V and C
  a_r6_keep_vc: assert property (@(posedge clk) disable iff (!rst_n)
    keep_vc_cls |=> (flag_v == $past(flag_v)) && (flag_c == $past(flag_c)));

  // R7: bit-test copies the memory operand's two top bits
  a_r7_bit_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 4'(CLS_BITT)) |=>
      (flag_n == $past(op_b[DW-1])) && (flag_v == $past(op_b[DW-2])));

  // R8: pull-status lands in every stored flag
  a_r8_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 4'(CLS_PULL)) |=>
      ({flag_n, flag_v, flag_d, flag_i, flag_z, flag_c} ==
       {$past(op_result[7:6]), $past(op_result[3:0])}));

  // R1: constant bit and pushed break bit
  a_r1_layout: assert property (@(posedge clk) disable iff (!rst_n)
    psr_o[5] && (psr_o[4] == brk_in));
endmodule

// File: tb/status_flag_unit_bench.sv
`timescale 1ns/1ps
module status_flag_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [3:0] op_class = '0;
  logic [7:0] op_result = '0, op_a = '0, op_b = '0;
  logic op_carry = 1'b0, flag_val = 1'b0, brk_in = 1'b0, irq_req = 1'b0;
  logic [2:0] flag_sel = '0;
  logic [7:0] psr_o;
  logic flag_n, flag_v, flag_d, flag_i, flag_z, flag_c, irq_take;

  int checks = 0, errors = 0;
  logic [7:0] model = 8'h24;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  status_flag_unit u_status_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_class(op_class), .op_result(op_result), .op_carry(op_carry),
    .op_a(op_a), .op_b(op_b), .flag_sel(flag_sel), .flag_val(flag_val),
    .brk_in(brk_in), .irq_req(irq_req), .psr_o(psr_o), .flag_n(flag_n),
    .flag_v(flag_v), .flag_d(flag_d), .flag_i(flag_i), .flag_z(flag_z),
    .flag_c(flag_c), .irq_take(irq_take)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: applies one operation and queues the expected pushed byte.
  task automatic do_op(input logic [3:0] cls, input logic [7:0] r, input logic c9,
                       input logic [7:0] a, input logic [7:0] b, input logic [2:0] sel,
                       input logic sv, input logic brk, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_class = cls; op_result = r; op_carry = c9;
    op_a = a; op_b = b; flag_sel = sel; flag_val = sv; brk_in = brk;
    case (cls)
      4'd0, 4'd1: begin model[7] = r[7]; model[1] = (r == 8'h00); end
      4'd2: begin
        model[7] = r[7]; model[1] = (r == 8'h00); model[0] = c9;
        model[6] = (a[7] == b[7]) && (r[7] != a[7]);
      end
      4'd3: begin
        model[7] = r[7]; model[1] = (r == 8'h00); model[0] = c9;
        model[6] = (a[7] != b[7]) && (r[7] != a[7]);
      end
      4'd4, 4'd5: begin model[7] = r[7]; model[1] = (r == 8'h00); model[0] = c9; end
      4'd6: begin model[7] = b[7]; model[6] = b[6]; model[1] = ((a & b) == 8'h00); end
      4'd7: model = {r[7:6], 2'b10, r[3:0]};
      4'd8: if (sel inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}) model[sel] = sv;
      default: ;
    endcase
    exp_q.push_back({model[7:5], brk, model[3:0]});
    tag_q.push_back(tag);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Monitor: pops expectations as updates take effect.
  initial begin
    forever begin
      @(posedge clk);
      if (op_valid === 1'b1) begin
        #2;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual %02h expected none", psr_o);
        end else begin
          string t;
          logic [7:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, psr_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset value", psr_o, 8'h24);
    check("R11 ready high", {7'd0, op_ready}, 8'h01);
    irq_req = 1'b1; #1;
    check("R10 masked after reset", {7'd0, irq_take}, 8'h00);
    brk_in = 1'b1; #1;
    check("R1 break bit in push", psr_o, 8'h34);
    brk_in = 1'b0;

    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd2, 1'b0, 1'b0, "R9 clear I");
    #1 check("R10 unmasked", {7'd0, irq_take}, 8'h01);
    do_op(4'd2, 8'h82, 0, 8'h55, 8'h2D, 3'd0, 0, 0, "R5 add 85+45 overflow");
    do_op(4'd2, 8'h00, 1, 8'h80, 8'h80, 3'd0, 0, 0, "R4 add neg+neg zero carry");
    do_op(4'd3, 8'hA0, 0, 8'h50, 8'hB0, 3'd0, 0, 0, "R5 sub overflow borrow");
    do_op(4'd3, 8'h02, 1, 8'h05, 8'h03, 3'd0, 0, 0, "R5 sub no overflow");
    do_op(4'd2, 8'h82, 0, 8'h55, 8'h2D, 3'd0, 0, 0, "R5 set V again");
    do_op(4'd0, 8'h00, 1, 8'h00, 8'h00, 3'd0, 0, 0, "R6 load zero keeps V C");
    do_op(4'd1, 8'hF0, 1, 8'h00, 8'h00, 3'd0, 0, 1, "R3 logical negative");
    do_op(4'd4, 8'h00, 1, 8'h00, 8'h00, 3'd0, 0, 0, "R4 compare equal");
    do_op(4'd5, 8'h40, 0, 8'h00, 8'h00, 3'd0, 0, 0, "R6 shift keeps V");
    do_op(4'd6, 8'h55, 0, 8'h0F, 8'hC0, 3'd0, 0, 0, "R7 bit-test zero and");
    do_op(4'd6, 8'h00, 1, 8'h01, 8'h01, 3'd0, 0, 0, "R7 bit-test nonzero");
    do_op(4'd7, 8'hFF, 0, 8'h00, 8'h00, 3'd0, 0, 0, "R8 pull all ones");
    #1 check("R10 masked after pull", {7'd0, irq_take}, 8'h00);
    do_op(4'd7, 8'h10, 0, 8'h00, 8'h00, 3'd0, 0, 0, "R8 pull ignores bit4");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd0, 1'b1, 0, "R9 set C");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd3, 1'b1, 0, "R9 set D");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd6, 1'b1, 0, "R9 set V");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd6, 1'b0, 0, "R9 clear V");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd7, 1'b1, 0, "R9 selector 7 ignored");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd5, 1'b0, 0, "R9 selector 5 ignored");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd4, 1'b1, 0, "R9 selector 4 ignored");
    do_op(4'd12, 8'h80, 1, 8'h00, 8'h00, 3'd0, 0, 0, "R11 unused class");
    do_op(4'd8, 8'h00, 0, 8'h00, 8'h00, 3'd2, 1'b1, 0, "R9 set I");
    #1 check("R10 masked by set I", {7'd0, irq_take}, 8'h00);

    // R11: valid low must not update even with an add presented
    @(negedge clk);
    op_valid = 1'b0; op_class = 4'd2; op_result = 8'h80; op_carry = 1'b1;
    op_a = 8'h7F; op_b = 8'h01;
    @(posedge clk); #2;
    check("R11 valid low no change", psr_o, {model[7:5], brk_in, model[3:0]});

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule